// File: doc/BRIEF.md
# Cache Pipeline Request Arbiter

This block is the stage-0 admission point of a four-stage data-cache main pipeline. Four request sources compete for the pipeline: coherence probes, refills, committed stores and atomics. Each offers a set index over a valid/ready handshake. In each cycle the arbiter takes at most one of them into stage 1. When it accepts a request, it issues the combined tag and meta lookup for that index in the same cycle.

A request gets in only when four things hold. It must be the highest-priority valid request. Its resources must be ready. Its set index must not match any occupied later stage (s1, s2 or s3). No meta write may be in progress. The arbiter keeps a valid bit and a set index for each later stage. A stage advances when its downstream hold input is low and the next stage is empty or is emptying in the same cycle. A stage that is stalled keeps its index.

Back-pressure rules: a source must keep its valid high and its index stable until it sees ready. Ready may depend on valid, but valid must never depend on ready. Ready is high only in the cycle of acceptance. A request that is blocked waits in place, and no lower-priority source may pass it.

Top module: `cache_pipe_arbiter`

## Requirements
- R1: Sources are ranked probe (index 0) above refill (1), store (2) and atomic (3). Only the highest-ranked valid request can be accepted. While it is blocked, every lower-ranked source sees ready low.
- R2: At most one ready is high in any cycle, and only for a source whose valid is high. With no valid request, no ready is high.
- R3: Probe, refill and atomic requests need `shared_res_ok` high. A store request is gated only by `store_res_ok` and ignores `shared_res_ok`.
- R4: A request whose index equals the index held in a valid s1, s2 or s3 is not accepted. An index left behind in an invalid stage has no effect.
- R5: While `meta_wr_busy` is high, no request is accepted.
- R6: A request is accepted only if s1 is empty or s1 moves on in that same cycle. s1 moves on when `stg_hold[0]` is low and s2 is empty or moving.
- R7: In the cycle of acceptance, `lookup_en` is high and `lookup_idx` equals the accepted index. In other cycles `lookup_en` is low.
- R8: An accepted index is in s1 one cycle later. Stage k moves to k+1 (or retires from s3) when `stg_hold[k]` is low and the next stage is free. A held stage keeps its valid bit and index.
- R9: While `rst_n` is low, all stage valid bits are 0 and no ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_valid | input | 1 | Probe request present |
| probe_idx | input | IDX_W | Probe set index |
| probe_ready | output | 1 | Probe accepted this cycle |
| refill_valid | input | 1 | Refill request present |
| refill_idx | input | IDX_W | Refill set index |
| refill_ready | output | 1 | Refill accepted this cycle |
| store_valid | input | 1 | Committed store request present |
| store_idx | input | IDX_W | Store set index |
| store_ready | output | 1 | Store accepted this cycle |
| amo_valid | input | 1 | Atomic request present |
| amo_idx | input | IDX_W | Atomic set index |
| amo_ready | output | 1 | Atomic accepted this cycle |
| shared_res_ok | input | 1 | Resources ready for probe, refill and atomic |
| store_res_ok | input | 1 | Resources ready for stores (separate path) |
| meta_wr_busy | input | 1 | Meta array write in progress |
| stg_hold | input | LATER_STAGES | Per-stage stall from downstream; bit 0 is s1 |
| lookup_en | output | 1 | Tag and meta read request |
| lookup_idx | output | IDX_W | Set index for the lookup |
| stg_valid | output | LATER_STAGES | Occupancy of s1..s3, bit 0 is s1 |
| stg_idx | output | LATER_STAGES*IDX_W | Indices of s1..s3, s1 in the low field |

## Verification
The bench drives the same index into the pipeline one cycle after another. This tests that the clash is detected against s1, then s2, then s3, and that it is released once the stage retires. A design that skipped one stage would accept too early. A design that ignored the valid bits would stay blocked on a stale index. A blocked probe placed next to a clean store checks that a lower source cannot overtake. Swapped resource gating shows up when `shared_res_ok` is low and `store_res_ok` is high, and when the two values are reversed. Holding s1 full, then releasing only s1 while s2 is held, checks that a full pipe is not overwritten, that indices stay put under a stall, and that a request is accepted in the very cycle s1 drains.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
  localparam int SRC_N      = 4;
  localparam int SRC_PROBE  = 0;
  localparam int SRC_REFILL = 1;
  localparam int SRC_STORE  = 2;
  localparam int SRC_AMO    = 3;
  localparam logic [SRC_N-1:0] STORE_MASK = 4'b0100;
endpackage

// File: rtl/cpa_prio_pick.sv
module cpa_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick
);
  // lowest index wins
  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpa_set_hazard.sv
module cpa_set_hazard #(
  parameter int IDX_W  = 6,
  parameter int STAGES = 3
) (
  input  logic [IDX_W-1:0]        cand_idx,
  input  logic [STAGES-1:0]       stg_valid,
  input  logic [STAGES*IDX_W-1:0] stg_idx,
  output logic                    conflict
);
  logic [STAGES-1:0] hit;

  for (genvar g = 0; g < STAGES; g++) begin : g_cmp
    assign hit[g] = stg_valid[g] && (stg_idx[g*IDX_W +: IDX_W] == cand_idx);
  end

  assign conflict = |hit;
endmodule

// File: rtl/cpa_stage_track.sv
module cpa_stage_track #(
  parameter int IDX_W  = 6,
  parameter int STAGES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [IDX_W-1:0]        load_idx,
  input  logic [STAGES-1:0]       hold,
  output logic                    can_take,
  output logic [STAGES-1:0]       valid,
  output logic [STAGES*IDX_W-1:0] idx_flat
);
  logic [STAGES-1:0] move;
  logic [IDX_W-1:0]  idx_q [STAGES];

  // walk from the last stage back so each stage sees whether its successor frees up
  always_comb begin
    logic nxt_free;
    nxt_free = 1'b1;
    move     = '0;
    for (int k = STAGES - 1; k >= 0; k--) begin
      move[k]  = valid[k] && !hold[k] && nxt_free;
      nxt_free = !valid[k] || move[k];
    end
    can_take = nxt_free;
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    logic             fill;
    logic [IDX_W-1:0] fill_idx;
    if (g == 0) begin : g_head
      assign fill     = load;
      assign fill_idx = load_idx;
    end else begin : g_body
      assign fill     = move[g-1];
      assign fill_idx = idx_q[g-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid[g] <= 1'b0;
        idx_q[g] <= '0;
      end else begin
        if (fill) begin
          valid[g] <= 1'b1;
          idx_q[g] <= fill_idx;
        end else if (move[g]) begin
          valid[g] <= 1'b0;
        end
      end
    end

    assign idx_flat[g*IDX_W +: IDX_W] = idx_q[g];

    // R8: a held stage keeps its content
    assert_stage_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid[g] && hold[g]) |=> (valid[g] && $stable(idx_q[g])));
  end

  // R8: accepted index lands in s1 next cycle
  assert_s1_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (valid[0] && idx_q[0] == $past(load_idx)));

  // R6: never load into an occupied, non-draining s1
  assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!valid[0] || move[0]));
endmodule

// File: rtl/cache_pipe_arbiter.sv
module cache_pipe_arbiter
  import cpa_pkg::*;
#(
  parameter int IDX_W        = 6,
  parameter int LATER_STAGES = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          probe_valid,
  input  logic [IDX_W-1:0]              probe_idx,
  output logic                          probe_ready,
  input  logic                          refill_valid,
  input  logic [IDX_W-1:0]              refill_idx,
  output logic                          refill_ready,
  input  logic                          store_valid,
  input  logic [IDX_W-1:0]              store_idx,
  output logic                          store_ready,
  input  logic                          amo_valid,
  input  logic [IDX_W-1:0]              amo_idx,
  output logic                          amo_ready,
  input  logic                          shared_res_ok,
  input  logic                          store_res_ok,
  input  logic                          meta_wr_busy,
  input  logic [LATER_STAGES-1:0]       stg_hold,
  output logic                          lookup_en,
  output logic [IDX_W-1:0]              lookup_idx,
  output logic [LATER_STAGES-1:0]       stg_valid,
  output logic [LATER_STAGES*IDX_W-1:0] stg_idx
);
  logic [SRC_N-1:0] req_v;
  logic [IDX_W-1:0] req_idx [SRC_N];
  logic [SRC_N-1:0] cand_oh;
  logic [SRC_N-1:0] grant;
  logic [IDX_W-1:0] cand_idx;
  logic             conflict;
  logic             s1_take;
  logic             path_clear;
  logic             store_go;
  logic             shared_go;

  assign req_v = {amo_valid, store_valid, refill_valid, probe_valid};
  assign req_idx[SRC_PROBE]  = probe_idx;
  assign req_idx[SRC_REFILL] = refill_idx;
  assign req_idx[SRC_STORE]  = store_idx;
  assign req_idx[SRC_AMO]    = amo_idx;

  cpa_prio_pick #(.N(SRC_N)) u_pick (
    .req  (req_v),
    .pick (cand_oh)
  );

  always_comb begin
    cand_idx = '0;
    for (int i = 0; i < SRC_N; i++) begin
      if (cand_oh[i]) cand_idx = req_idx[i];
    end
  end

  cpa_set_hazard #(.IDX_W(IDX_W), .STAGES(LATER_STAGES)) u_hazard (
    .cand_idx  (cand_idx),
    .stg_valid (stg_valid),
    .stg_idx   (stg_idx),
    .conflict  (conflict)
  );

  // common conditions; resource readiness splits into two paths below
  assign path_clear = rst_n && !conflict && !meta_wr_busy && s1_take;

  // committed stores: own readiness path
  assign store_go  = cand_oh[SRC_STORE] && store_res_ok && path_clear;
  // probe, refill, atomic: shared readiness path
  assign shared_go = ((cand_oh & ~STORE_MASK) != '0) && shared_res_ok && path_clear;

  assign grant = (store_go || shared_go) ? cand_oh : '0;

  assign probe_ready  = grant[SRC_PROBE];
  assign refill_ready = grant[SRC_REFILL];
  assign store_ready  = grant[SRC_STORE];
  assign amo_ready    = grant[SRC_AMO];
  assign lookup_en    = |grant;
  assign lookup_idx   = cand_idx;

  cpa_stage_track #(.IDX_W(IDX_W), .STAGES(LATER_STAGES)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (lookup_en),
    .load_idx (cand_idx),
    .hold     (stg_hold),
    .can_take (s1_take),
    .valid    (stg_valid),
    .idx_flat (stg_idx)
  );

  // R2: one grant at most, only to a requester
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_has_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req_v) == '0);

  // R1: a pending probe shuts out all lower sources
  assert_probe_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid |-> !(refill_ready || store_ready || amo_ready));

  // R3: each path honours its own readiness input
  assert_store_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    store_ready |-> store_res_ok);
  assert_shared_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_ready || refill_ready || amo_ready) |-> shared_res_ok);

  // R5: meta write blocks admission
  assert_meta_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    meta_wr_busy |-> !lookup_en);

  // R4: no accepted index equals a valid later stage
  for (genvar g = 0; g < LATER_STAGES; g++) begin : g_chk
    assert_no_set_clash_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lookup_en && stg_valid[g]) |-> (stg_idx[g*IDX_W +: IDX_W] != lookup_idx));
  end
endmodule

// File: tb/cache_pipe_arbiter_tb_top.sv
`timescale 1ns/1ps
module cache_pipe_arbiter_tb_top;
  localparam int IW = 6;
  localparam int NS = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic probe_valid, refill_valid, store_valid, amo_valid;
  logic [IW-1:0] probe_idx, refill_idx, store_idx, amo_idx;
  logic probe_ready, refill_ready, store_ready, amo_ready;
  logic shared_res_ok, store_res_ok, meta_wr_busy;
  logic [NS-1:0] stg_hold;
  logic lookup_en;
  logic [IW-1:0] lookup_idx;
  logic [NS-1:0] stg_valid;
  logic [NS*IW-1:0] stg_idx;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    int    src;
    int    idx;
    string req;
  } exp_t;
  exp_t sbq[$];

  always #2.5 clk = ~clk;

  cache_pipe_arbiter #(.IDX_W(IW), .LATER_STAGES(NS)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .probe_valid(probe_valid), .probe_idx(probe_idx), .probe_ready(probe_ready),
    .refill_valid(refill_valid), .refill_idx(refill_idx), .refill_ready(refill_ready),
    .store_valid(store_valid), .store_idx(store_idx), .store_ready(store_ready),
    .amo_valid(amo_valid), .amo_idx(amo_idx), .amo_ready(amo_ready),
    .shared_res_ok(shared_res_ok), .store_res_ok(store_res_ok),
    .meta_wr_busy(meta_wr_busy), .stg_hold(stg_hold),
    .lookup_en(lookup_en), .lookup_idx(lookup_idx),
    .stg_valid(stg_valid), .stg_idx(stg_idx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic setreq(input logic [3:0] v, input int i0, input int i1, input int i2, input int i3);
    {amo_valid, store_valid, refill_valid, probe_valid} = v;
    probe_idx  = IW'(i0);
    refill_idx = IW'(i1);
    store_idx  = IW'(i2);
    amo_idx    = IW'(i3);
  endtask

  // driver side of the scoreboard: src 4 means no acceptance this cycle
  task automatic expect_cyc(input int src, input int idx, input string req);
    exp_t e;
    e.src = src;
    e.idx = idx;
    e.req = req;
    sbq.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      tick();
      setreq(4'b0000, 0, 0, 0, 0);
      expect_cyc(4, 0, "R2 idle");
    end
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    logic [3:0] gv;
    logic [3:0] ev;
    exp_t e;
    #1.5;
    gv = {amo_ready, store_ready, refill_ready, probe_ready};
    if (sbq.size() > 0) begin
      e  = sbq.pop_front();
      ev = (e.src < 4) ? 4'(1 << e.src) : 4'b0000;
      check(gv == ev, {e.req, " grant vector"}, int'(gv), int'(ev));
      if (e.src < 4) begin
        check(lookup_en == 1'b1, {e.req, " R7 lookup_en"}, int'(lookup_en), 1);
        check(int'(lookup_idx) == e.idx, {e.req, " R7 lookup_idx"}, int'(lookup_idx), e.idx);
      end else begin
        check(lookup_en == 1'b0, {e.req, " R7 lookup_en idle"}, int'(lookup_en), 0);
      end
    end else begin
      check(gv == 4'b0000, "R2 grant with nothing expected", int'(gv), 0);
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired: actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    shared_res_ok = 1'b1;
    store_res_ok  = 1'b1;
    meta_wr_busy  = 1'b0;
    stg_hold      = '0;
    setreq(4'b0001, 1, 0, 0, 0);
    repeat (3) tick();
    #1;
    check(probe_ready == 1'b0, "R9 no ready in reset", int'(probe_ready), 0);
    check(stg_valid == '0, "R9 stages empty in reset", int'(stg_valid), 0);

    tick();
    rst_n = 1'b1;
    setreq(4'b0000, 0, 0, 0, 0);
    expect_cyc(4, 0, "R2 nothing valid");

    // R1 priority walk
    tick(); setreq(4'b1111, 1, 2, 3, 4); expect_cyc(0, 1, "R1 probe first");
    tick(); setreq(4'b1110, 1, 2, 3, 4); expect_cyc(1, 2, "R1 refill second");
    #1;
    check(stg_valid[0] && stg_idx[IW-1:0] == 1, "R8 s1 holds probe idx", int'(stg_idx[IW-1:0]), 1);
    tick(); setreq(4'b1100, 1, 2, 3, 4); expect_cyc(2, 3, "R1 store third");
    tick(); setreq(4'b1000, 1, 2, 3, 4); expect_cyc(3, 4, "R1 atomic last");
    tick(); setreq(4'b0000, 0, 0, 0, 0); expect_cyc(4, 0, "R2 drained");
    #1;
    check(stg_valid == 3'b111, "R8 all stages full", int'(stg_valid), 7);
    check(stg_idx[3*IW-1:2*IW] == 2, "R8 s3 idx", int'(stg_idx[3*IW-1:2*IW]), 2);
    check(stg_idx[2*IW-1:IW] == 3, "R8 s2 idx", int'(stg_idx[2*IW-1:IW]), 3);
    idle(4);

    // R4 clash against s1, s2, s3 then release
    tick(); setreq(4'b0100, 0, 0, 9, 0); expect_cyc(2, 9, "R4 store idx9");
    tick(); setreq(4'b1000, 0, 0, 0, 9); expect_cyc(4, 0, "R4 clash s1");
    tick(); expect_cyc(4, 0, "R4 clash s2");
    tick(); expect_cyc(4, 0, "R4 clash s3");
    tick(); expect_cyc(3, 9, "R4 invalid stage ignored");
    idle(4);

    // R1 blocked higher source holds back lower
    tick(); setreq(4'b0001, 5, 0, 0, 0); expect_cyc(0, 5, "R1 probe idx5");
    tick(); setreq(4'b0101, 5, 0, 6, 0); expect_cyc(4, 0, "R1 blocked probe holds store");
    tick(); setreq(4'b0100, 0, 0, 6, 0); expect_cyc(2, 6, "R1 store after probe leaves");
    idle(4);

    // R3 separate readiness paths
    tick(); shared_res_ok = 1'b0; setreq(4'b0110, 0, 7, 8, 0); expect_cyc(4, 0, "R3 refill needs shared");
    tick(); setreq(4'b0100, 0, 0, 8, 0); expect_cyc(2, 8, "R3 store ignores shared");
    tick(); shared_res_ok = 1'b1; store_res_ok = 1'b0;
    setreq(4'b1100, 0, 0, 10, 11); expect_cyc(4, 0, "R3 store needs store_res_ok");
    tick(); setreq(4'b1000, 0, 0, 0, 11); expect_cyc(3, 11, "R3 atomic on shared");
    tick(); store_res_ok = 1'b1; setreq(4'b0000, 0, 0, 0, 0); expect_cyc(4, 0, "R2 idle");
    idle(4);

    // R5 meta write in progress
    tick(); meta_wr_busy = 1'b1; setreq(4'b0001, 12, 0, 0, 0); expect_cyc(4, 0, "R5 meta busy");
    tick(); meta_wr_busy = 1'b0; expect_cyc(0, 12, "R5 meta free");
    idle(4);

    // R6 / R8 back-pressure
    tick(); stg_hold = 3'b111; setreq(4'b0001, 20, 0, 0, 0); expect_cyc(0, 20, "R6 s1 empty");
    tick(); setreq(4'b0010, 0, 21, 0, 0); expect_cyc(4, 0, "R6 s1 full held");
    #1;
    check(stg_valid == 3'b001, "R8 only s1 valid", int'(stg_valid), 1);
    check(stg_idx[IW-1:0] == 20, "R8 s1 keeps idx", int'(stg_idx[IW-1:0]), 20);
    tick(); stg_hold = 3'b110; expect_cyc(1, 21, "R6 s1 drains same cycle");
    tick(); setreq(4'b0100, 0, 0, 22, 0); expect_cyc(4, 0, "R6 s2 held blocks s1");
    #1;
    check(stg_valid == 3'b011, "R8 s1 s2 valid", int'(stg_valid), 3);
    check(stg_idx[IW-1:0] == 21, "R8 s1 idx21", int'(stg_idx[IW-1:0]), 21);
    check(stg_idx[2*IW-1:IW] == 20, "R8 s2 idx20", int'(stg_idx[2*IW-1:IW]), 20);
    tick(); expect_cyc(4, 0, "R6 still held");
    #1;
    check(stg_idx[2*IW-1:IW] == 20, "R8 s2 stable under hold", int'(stg_idx[2*IW-1:IW]), 20);
    tick(); stg_hold = 3'b000; expect_cyc(2, 22, "R6 release");
    idle(5);

    tick();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule